// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serialises one parallel character at a time into an asynchronous frame on a single output line. A character is offered on a valid/ready handshake. The block paces every bit with a clock enable that runs at sixteen times the bit rate. It does not generate that enable itself; it only counts it.

A line-configuration input selects the number of data bits (five to eight), the parity mode (none, odd or even) and the length of the stop period. The stop period can be one bit, one and a half bits or two bits. The configuration is captured when a character is accepted, so it can change freely while a frame is on the line.

A separate break input pulls the line low for as long as it is held. Frame timing keeps running underneath a break. The block reports whether it is idle or busy, and it can take the next character in the same cycle that the current stop period ends. That gives back-to-back frames with no idle gap.

Top module: `async_tx_framer`

## Requirements
- R1: After reset and between frames, `txd` is high, `tx_idle` is 1, `tx_busy` is 0 and `char_ready` is 1.
- R2: Each frame bit lasts exactly 16 cycles in which `os_tick` is 1. While `os_tick` is 0 the frame does not advance; a character can still be accepted in that state.
- R3: A frame is one low start bit, then the data bits least significant bit first, then the parity bit if enabled, then a high stop period.
- R4: `cfg_wlen` encodes the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of `char_data` above the selected length never reach the line.
- R5: `cfg_parity` encodes the parity mode. 1 gives odd parity (data plus parity bit hold an odd number of ones), 2 gives even parity, and 0 or 3 sends no parity bit.
- R6: With `cfg_two_stop` at 0 the stop period is 16 enables. With `cfg_two_stop` at 1 and 5 data bits it is 24 enables.
- R7: With `cfg_two_stop` at 1 and 6, 7 or 8 data bits the stop period is 32 enables.
- R8: Length, parity and stop settings are sampled in the cycle a character is accepted. Changing them during a frame does not alter that frame.
- R9: `char_ready` is 1 only when idle or on the enable that ends the stop period. A character accepted there starts its start bit at once, with no idle cycle between frames.
- R10: While `cfg_break` is 1, `txd` is low in the same cycle, whether idle or mid-frame. The frame sequence keeps its timing underneath, and the line returns to the frame value when the break is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| char_data | input | DATA_W | Character to send |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Character accepted when valid is also 1 |
| cfg_wlen | input | 2 | Data length code |
| cfg_parity | input | 2 | Parity mode code |
| cfg_two_stop | input | 1 | Long stop period request |
| cfg_break | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| tx_idle | output | 1 | No frame in progress |
| tx_busy | output | 1 | Frame in progress |

## Verification
The bench first targets the stop-period lengths. A design that ignored the data length would stretch a five-bit long stop to 32 enables, and one that ignored the long-stop request would end every frame after 16. It then changes the configuration in the middle of a frame. A transmitter that read it live would reshape the frame, and the time to idle would move. Back-to-back handover is checked at the exact enable where the stop period ends: an off-by-one there either leaves an idle cycle or lets a character in mid-stop. Break is applied in the middle of a frame, and a frame that stalled during the break would finish late.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_ODD  = 2'd1,
      PAR_EVEN = 2'd2,
      PAR_OFF  = 2'd3
   } par_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } tx_state_e;

   typedef struct packed {
      logic [1:0] wlen;
      par_mode_e  par;
      logic       two_stop;
   } line_cfg_t;

   function automatic logic par_enabled(par_mode_e p);
      return (p == PAR_ODD) || (p == PAR_EVEN);
   endfunction

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
   parameter int OVS = 16,
   parameter int CW  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          run,
   input  logic          restart,
   input  logic [CW-1:0] limit,
   output logic          bit_end
);

   logic [CW-1:0] cnt_q;

   assign bit_end = run && tick && (cnt_q == (limit - CW'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run && tick) begin
         cnt_q <= bit_end ? '0 : cnt_q + CW'(1);
      end
   end

   if (OVS < 2) begin : g_bad_ovs
      $error("sertx_bit_timer: OVS must be at least 2");
   end

   AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < limit); // R6

   AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter import sertx_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        wlen,
   input  par_mode_e         par,
   output logic              cur_bit,
   output logic              par_bit
);

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] masked;
   logic              par_q;

   function automatic logic [DATA_W-1:0] len_mask(logic [1:0] wl);
      logic [DATA_W-1:0] m;
      for (int i = 0; i < DATA_W; i++) begin
         m[i] = (i < MIN_W + int'(wl));
      end
      return m;
   endfunction

   assign masked = data & len_mask(wlen);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         par_q <= 1'b0;
      end else if (load) begin
         sh_q  <= masked;
         par_q <= (par == PAR_ODD) ? ~(^masked) : (^masked);
      end else if (shift) begin
         sh_q  <= sh_q >> 1;
      end
   end

   assign cur_bit = sh_q[0];
   assign par_bit = par_q;

   if (DATA_W < MIN_W || DATA_W - MIN_W > 3) begin : g_bad_width
      $error("sertx_shifter: DATA_W must lie within MIN_W..MIN_W+3");
   end

   AST_SHIFT_EMPTIES_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !load) |=> !sh_q[DATA_W-1]); // R4

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq import sertx_pkg::*; #(
   parameter int DATA_W    = 8,
   parameter int MIN_W     = 5,
   parameter int OVS       = 16,
   parameter bit HALF_STOP = 1'b1,
   parameter int CW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bit_end,
   input  logic          char_valid,
   input  line_cfg_t     cfg_in,
   output logic          char_ready,
   output logic          accept,
   output logic          shift,
   output tx_state_e     state,
   output line_cfg_t     cfg,
   output logic [CW-1:0] limit
);

   localparam int IW = $clog2(DATA_W);

   tx_state_e     state_q, state_d;
   line_cfg_t     cfg_q;
   logic [IW-1:0] idx_q;
   logic [IW:0]   last_idx;
   logic          stop_done;
   logic          last_data;
   logic [CW-1:0] short_stop;

   if (HALF_STOP) begin : g_half_stop
      assign short_stop = CW'(OVS + OVS / 2);
   end else begin : g_full_stop
      assign short_stop = CW'(2 * OVS);
   end

   assign last_idx   = (IW+1)'(MIN_W - 1) + (IW+1)'(cfg_q.wlen);
   assign last_data  = ({1'b0, idx_q} == last_idx);
   assign stop_done  = (state_q == ST_STOP) && bit_end;
   assign char_ready = (state_q == ST_IDLE) || stop_done;
   assign accept     = char_valid && char_ready;
   assign shift      = (state_q == ST_DATA) && bit_end;

   always_comb begin
      limit = CW'(OVS);
      if (state_q == ST_STOP && cfg_q.two_stop) begin
         limit = (cfg_q.wlen == 2'd0) ? short_stop : CW'(2 * OVS);
      end
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (accept) state_d = ST_START;
         ST_START:  if (bit_end) state_d = ST_DATA;
         ST_DATA:   if (bit_end && last_data)
                       state_d = par_enabled(cfg_q.par) ? ST_PARITY : ST_STOP;
         ST_PARITY: if (bit_end) state_d = ST_STOP;
         ST_STOP:   if (bit_end) state_d = accept ? ST_START : ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept) cfg_q <= cfg_in;
         if (state_q == ST_START) begin
            idx_q <= '0;
         end else if (shift) begin
            idx_q <= idx_q + IW'(1);
         end
      end
   end

   assign state = state_q;
   assign cfg   = cfg_q;

   AST_STALL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !accept) |=> $stable(state_q)); // R2

   AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (state_q == ST_START)); // R9

   AST_NO_READY_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q inside {ST_START, ST_DATA, ST_PARITY}) |-> !char_ready); // R9

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !accept) |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/async_tx_framer.sv
module async_tx_framer import sertx_pkg::*; #(
   parameter int DATA_W    = 8,
   parameter int MIN_W     = 5,
   parameter int OVS       = 16,
   parameter bit HALF_STOP = 1'b1,
   parameter bit OUT_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic [DATA_W-1:0] char_data,
   input  logic              char_valid,
   output logic              char_ready,
   input  logic [1:0]        cfg_wlen,
   input  logic [1:0]        cfg_parity,
   input  logic              cfg_two_stop,
   input  logic              cfg_break,
   output logic              txd,
   output logic              tx_idle,
   output logic              tx_busy
);

   localparam int CW = $clog2(2 * OVS + 1);

   line_cfg_t     cfg_in, cfg_cur;
   tx_state_e     state;
   logic          accept, shift, bit_end;
   logic          cur_bit, par_bit;
   logic          frame_bit, line_nxt;
   logic [CW-1:0] limit;

   if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("async_tx_framer: OVS must be even and at least 2");
   end

   assign cfg_in.wlen     = cfg_wlen;
   assign cfg_in.par      = par_mode_e'(cfg_parity);
   assign cfg_in.two_stop = cfg_two_stop;

   sertx_seq #(
      .DATA_W(DATA_W), .MIN_W(MIN_W), .OVS(OVS),
      .HALF_STOP(HALF_STOP), .CW(CW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(os_tick), .bit_end(bit_end),
      .char_valid(char_valid), .cfg_in(cfg_in), .char_ready(char_ready),
      .accept(accept), .shift(shift), .state(state), .cfg(cfg_cur),
      .limit(limit)
   );

   sertx_bit_timer #(.OVS(OVS), .CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(os_tick),
      .run(state != ST_IDLE), .restart(accept),
      .limit(limit), .bit_end(bit_end)
   );

   sertx_shifter #(.DATA_W(DATA_W), .MIN_W(MIN_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .shift(shift),
      .data(char_data), .wlen(cfg_in.wlen), .par(cfg_in.par),
      .cur_bit(cur_bit), .par_bit(par_bit)
   );

   always_comb begin
      case (state)
         ST_START:  frame_bit = 1'b0;
         ST_DATA:   frame_bit = cur_bit;
         ST_PARITY: frame_bit = par_bit;
         default:   frame_bit = 1'b1;
      endcase
   end

   assign line_nxt = cfg_break ? 1'b0 : frame_bit;
   assign tx_idle  = (state == ST_IDLE);
   assign tx_busy  = (state != ST_IDLE);

   if (OUT_REG) begin : g_out_reg
      logic txd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) txd_q <= 1'b1;
         else        txd_q <= line_nxt;
      end
      assign txd = txd_q;

      AST_BREAK_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         cfg_break |=> !txd); // R10
   end else begin : g_out_comb
      assign txd = line_nxt;

      AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_idle && !cfg_break) |-> txd); // R1
   end

   AST_PARITY_ONLY_IF_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PARITY) |-> par_enabled(cfg_cur.par)); // R5

endmodule

// File: tb/sim_async_tx_framer.sv
module sim_async_tx_framer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       os_tick = 1'b1;
   logic [7:0] char_data = '0;
   logic       char_valid = 1'b0;
   logic       char_ready;
   logic [1:0] cfg_wlen = 2'd3;
   logic [1:0] cfg_parity = 2'd0;
   logic       cfg_two_stop = 1'b0;
   logic       cfg_break = 1'b0;
   logic       txd, tx_idle, tx_busy;

   int n_checks = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   async_tx_framer u0 (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .char_data(char_data),
      .char_valid(char_valid), .char_ready(char_ready), .cfg_wlen(cfg_wlen),
      .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
      .cfg_break(cfg_break), .txd(txd), .tx_idle(tx_idle), .tx_busy(tx_busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(input int wl, input int pm, input bit two);
      cfg_wlen     = 2'(wl);
      cfg_parity   = 2'(pm);
      cfg_two_stop = two;
   endtask

   task automatic send(input logic [7:0] d);
      @(negedge clk);
      char_data  = d;
      char_valid = 1'b1;
      while (!char_ready) @(negedge clk);
      @(negedge clk);
      char_valid = 1'b0;
   endtask

   // Called at the first falling edge after acceptance; follows the frame to idle.
   task automatic frame(input logic [7:0] d, input int wl, input int pm,
                        input bit two, input string req, input int chg_at,
                        input int brk_from, input int brk_to);
      int n, p, body, stopt, total, bad, idle_at, k;
      logic [7:0] m;
      logic pb, expb;
      bit brk;
      n = 5 + wl;
      p = (pm == 1 || pm == 2) ? 1 : 0;
      body = 16 * (1 + n + p);
      stopt = two ? ((n == 5) ? 24 : 32) : 16;
      total = body + stopt;
      m = 8'hFF >> (8 - n);
      pb = ^(d & m);
      if (pm == 1) pb = ~pb;
      bad = 0;
      idle_at = -1;
      for (int i = 0; i < 1000; i++) begin
         if (i == chg_at) set_cfg(0, 2, 1);
         if (i == brk_from) cfg_break = 1'b1;
         if (i == brk_to) cfg_break = 1'b0;
         #1;
         brk = (i >= brk_from && i < brk_to);
         if (tx_idle) begin
            idle_at = i;
            break;
         end
         if (brk) begin
            if (txd !== 1'b0) bad++;
         end else if (i < body) begin
            if (i % 16 == 8) begin
               k = i / 16;
               if (k == 0) expb = 1'b0;
               else if (k <= n) expb = d[k-1];
               else expb = pb;
               if (txd !== expb) bad++;
            end
         end else if (txd !== 1'b1) begin
            bad++;
         end
         @(negedge clk);
      end
      cfg_break = 1'b0;
      chk(bad == 0, req, "frame bit errors", bad, 0);
      chk(idle_at == total, req, "cycles to idle", idle_at, total);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
      chk(tx_idle === 1'b1, "R1", "idle after reset", int'(tx_idle), 1);
      chk(tx_busy === 1'b0, "R1", "busy after reset", int'(tx_busy), 0);
      chk(char_ready === 1'b1, "R1", "ready after reset", int'(char_ready), 1);
   endtask

   task automatic t_formats();
      set_cfg(3, 0, 0); send(8'hA5); frame(8'hA5, 3, 0, 0, "R3 R4", -1, -1, -1);
      set_cfg(0, 1, 1); send(8'hF3); frame(8'hF3, 0, 1, 1, "R6 R5 R4", -1, -1, -1);
      set_cfg(2, 2, 1); send(8'h5B); frame(8'h5B, 2, 2, 1, "R7 R5", -1, -1, -1);
      set_cfg(1, 3, 0); send(8'hFF); frame(8'hFF, 1, 3, 0, "R5 R4", -1, -1, -1);
      set_cfg(3, 1, 1); send(8'h00); frame(8'h00, 3, 1, 1, "R7 R5", -1, -1, -1);
      #1;
      chk(txd === 1'b1 && tx_idle === 1'b1, "R1", "line high between frames",
          int'(txd), 1);
   endtask

   task automatic t_cfg_midframe();
      set_cfg(3, 2, 0); send(8'h3C);
      frame(8'h3C, 3, 2, 0, "R8", 20, -1, -1);
      send(8'h1F);
      frame(8'h1F, 0, 2, 1, "R8", -1, -1, -1);
   endtask

   task automatic t_back_to_back();
      set_cfg(3, 0, 0);
      @(negedge clk);
      char_data = 8'h81; char_valid = 1'b1;
      while (!char_ready) @(negedge clk);
      @(negedge clk);
      char_data = 8'h7E;
      repeat (5) @(negedge clk);
      #1;
      chk(char_ready === 1'b0, "R9", "ready mid-frame", int'(char_ready), 0);
      repeat (154) @(negedge clk);
      #1;
      chk(char_ready === 1'b1, "R9", "ready on last stop enable", int'(char_ready), 1);
      @(negedge clk);
      #1;
      chk(txd === 1'b0, "R9", "next start bit without gap", int'(txd), 0);
      chk(tx_idle === 1'b0, "R9", "no idle between frames", int'(tx_idle), 0);
      char_valid = 1'b0;
      frame(8'h7E, 3, 0, 0, "R9", -1, -1, -1);
   endtask

   task automatic t_break();
      @(negedge clk);
      cfg_break = 1'b1;
      #1;
      chk(txd === 1'b0, "R10", "break while idle", int'(txd), 0);
      repeat (3) @(negedge clk);
      #1;
      chk(txd === 1'b0 && tx_idle === 1'b1, "R10", "break held, still idle",
          int'(txd), 0);
      cfg_break = 1'b0;
      #1;
      chk(txd === 1'b1, "R10", "line restored after break", int'(txd), 1);
      set_cfg(3, 0, 0); send(8'h55);
      frame(8'h55, 3, 0, 0, "R10", -1, 30, 70);
   endtask

   task automatic t_stall();
      os_tick = 1'b0;
      set_cfg(3, 0, 0); send(8'hC3);
      repeat (40) @(negedge clk);
      #1;
      chk(txd === 1'b0, "R2", "start bit held without enables", int'(txd), 0);
      chk(tx_busy === 1'b1, "R2", "busy while stalled", int'(tx_busy), 1);
      @(negedge clk);
      os_tick = 1'b1;
      frame(8'hC3, 3, 0, 0, "R2", -1, -1, -1);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_formats();
      t_cfg_midframe();
      t_back_to_back();
      t_break();
      t_stall();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule